// File: doc/BRIEF.md
# Half-Band Decimate-by-Two Filter with Hardwired Signed-Digit Multipliers

This block is the second rate-reduction stage of an oversampled converter chain. It takes 24-bit signed samples arriving at 28 kHz (one per cycle that `in_valid` is high) and delivers filtered samples at 14 kHz. The filter is a seven-tap, linear-phase half-band FIR. The centre tap is exactly one half. The taps two places from the centre are zero. The two remaining distinct coefficients are 0.288470… (48'h24EC98258D1E in Q1.47) next to the centre and 0.25 minus that value at the outer ends.

No general multiplier is used. The two mirrored pairs of taps are first summed. Each pair sum then feeds a fixed network of shifted adds and subtracts. That network is built from the canonical signed-digit recoding of its coefficient, which the code computes at elaboration time. The centre product is the sample weighted by one half, and it needs no adder at all. A phase toggle, cleared by reset, starts the filter on every second accepted sample, so each output appears one cycle after the even-numbered input that completes it.

Top module: `hb_decim2`

## Requirements
- R1: While reset is asserted and until the first output, `out_valid` is 0 and `out_data` is 0.
- R2: Counting accepted inputs from reset as 1, 2, 3, …, `out_valid` is high for exactly one cycle, namely the cycle after the 2nd, 4th, 6th, … accepted input, and is low in every other cycle.
- R3: A cycle with `in_valid` low has no effect. The value on `in_data` in that cycle enters no later result, and the decimation phase does not advance.
- R4: With x(n) the accepted input samples (x(n)=0 before the first one since reset), the output produced for the input of odd index n (0-based) equals floor(S / 2^47). Here S = A·(x(n)+x(n−6)) + B·(x(n−2)+x(n−4)) + 2^46·x(n−3), with B = 0x24EC98258D1E and A = 2^45 − B. `out_data` is a 25-bit two's complement number with the same scale as the input.
- R5: An isolated impulse that lands on an even input index yields outputs weighted by the outer and the neighbour-of-centre coefficients only. An impulse on an odd index yields only the half-weight centre value (floor of x/2) and zeros.
- R6: The DC gain is exactly one. After seven equal inputs x, the next output equals x with no error.
- R7: Full-scale inputs of either sign, placed so as to maximise the filter gain, produce the correct result without wrap in the 25-bit output.
- R8: `out_data` holds its value in every cycle that `out_valid` is low.
- R9: Reset clears the sample history and the phase, so samples accepted before reset contribute nothing afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A new input sample is present this cycle |
| in_data | input | 24 | Input sample, two's complement, Q1.23 |
| out_valid | output | 1 | A decimated output is present this cycle |
| out_data | output | 25 | Output sample, two's complement, Q2.23 |

## Verification
Impulses placed on even and on odd input indices separate the two polyphase branches: one shows the signed-digit coefficient networks, the other only the half-weight centre path. Long runs of a constant value check the exact unity DC gain, and a full-scale pattern of opposite signs places the largest sum on the widest path to expose any truncation or wrap. Random streams, with and without idle gaps that carry garbage on the data lines, are compared against an exact wide-integer model to check the sum and the decimation phase, and to confirm that idle cycles neither shift the history nor advance the phase. A reset in the middle of a stream checks that the history is gone.

// File: rtl/hb_pkg.sv
package hb_pkg;

    // Filter structure: order 6, seven taps, centre weight one half.
    localparam int ORDER     = 6;
    localparam int CENTRE    = ORDER / 2;
    localparam int NZ_PAIRS  = (CENTRE + 1) / 2;

    // Coefficient format: signed, COEF_FRAC fractional bits.
    localparam int COEF_W    = 48;
    localparam int COEF_FRAC = 47;

    // Neighbour-of-centre weight, and the outer weight chosen so the taps sum to one.
    localparam logic signed [COEF_W-1:0] COEF_INNER = 48'sh24EC98258D1E;
    localparam logic signed [COEF_W-1:0] COEF_OUTER = 48'sh200000000000 - COEF_INNER;

    // Index i serves the tap pair at distance 2*i+1 from the centre.
    localparam logic signed [COEF_W-1:0] NZ_COEF [NZ_PAIRS] = '{COEF_INNER, COEF_OUTER};

    // Canonical signed-digit recoding: returns the mask of +1 digits
    // (want_neg = 0) or of -1 digits (want_neg = 1) of a signed constant.
    function automatic logic [COEF_W:0] csd_mask(input logic signed [COEF_W-1:0] c,
                                                 input logic want_neg);
        logic signed [COEF_W+1:0] cs;
        logic [COEF_W+1:0]        mag;
        logic [COEF_W:0]          m;
        logic                     flip;
        logic                     dp;
        logic                     dn;
        flip = c[COEF_W-1];
        cs   = (COEF_W+2)'(c);
        mag  = flip ? -cs : cs;
        m    = '0;
        for (int i = 0; i <= COEF_W; i++) begin
            dp = 1'b0;
            dn = 1'b0;
            if (mag[0]) begin
                if (mag[1]) begin
                    dn  = 1'b1;
                    mag = mag + (COEF_W+2)'(1);
                end else begin
                    dp  = 1'b1;
                    mag = mag - (COEF_W+2)'(1);
                end
            end
            m[i] = want_neg ? (flip ? dp : dn) : (flip ? dn : dp);
            mag  = mag >> 1;
        end
        return m;
    endfunction

endpackage

// File: rtl/hb_csd_mult.sv
module hb_csd_mult
    import hb_pkg::*;
#(
    parameter int                        IN_W = 25,
    parameter logic signed [COEF_W-1:0]  COEF = '0,
    localparam int                       OUT_W = IN_W + COEF_W + 1
) (
    input  logic [IN_W-1:0]  a,
    output logic [OUT_W-1:0] p
);

    localparam logic [COEF_W:0] POS_M = csd_mask(COEF, 1'b0);
    localparam logic [COEF_W:0] NEG_M = csd_mask(COEF, 1'b1);

    logic signed [OUT_W-1:0] a_ext;
    logic signed [OUT_W-1:0] term [COEF_W+1];
    logic signed [OUT_W-1:0] sum;

    assign a_ext = OUT_W'($signed(a));

    // One shifted copy per nonzero digit; zero digits cost nothing.
    for (genvar k = 0; k <= COEF_W; k++) begin : g_digit
        if (POS_M[k]) begin : g_add
            assign term[k] = a_ext <<< k;
        end else if (NEG_M[k]) begin : g_sub
            assign term[k] = -(a_ext <<< k);
        end else begin : g_zero
            assign term[k] = '0;
        end
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k <= COEF_W; k++) begin
            sum = sum + term[k];
        end
    end

    assign p = sum;

endmodule

// File: rtl/hb_tapline.sv
module hb_tapline
    import hb_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [DATA_W-1:0]               in_data,
    output logic [NZ_PAIRS-1:0][DATA_W:0]   pair_sum,
    output logic [DATA_W-1:0]               centre
);

    localparam int HIST = ORDER;

    typedef struct packed {
        logic [HIST-1:0][DATA_W-1:0] hist;
    } tap_t;

    tap_t st_d, st_q;

    // Next state: shift only on an accepted sample.
    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            st_d.hist[0] = in_data;
            for (int k = 1; k < HIST; k++) begin
                st_d.hist[k] = st_q.hist[k-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Pre-add mirrored taps; window index 0 is the incoming sample,
    // index j > 0 is history entry j-1.
    for (genvar i = 0; i < NZ_PAIRS; i++) begin : g_pair
        localparam int LO = CENTRE - (2 * i + 1);
        localparam int HI = CENTRE + (2 * i + 1);
        logic signed [DATA_W:0] lo_v;
        logic signed [DATA_W:0] hi_v;
        if (LO == 0) begin : g_lo_in
            assign lo_v = (DATA_W+1)'($signed(in_data));
        end else begin : g_lo_hist
            assign lo_v = (DATA_W+1)'($signed(st_q.hist[LO-1]));
        end
        assign hi_v        = (DATA_W+1)'($signed(st_q.hist[HI-1]));
        assign pair_sum[i] = lo_v + hi_v;
    end

    assign centre = st_q.hist[CENTRE-1];

    AST_TAPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q)); // R3

endmodule

// File: rtl/hb_decim2.sv
module hb_decim2
    import hb_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   in_data,
    output logic                out_valid,
    output logic [DATA_W:0]     out_data
);

    localparam int PRE_W  = DATA_W + 1;
    localparam int PROD_W = PRE_W + COEF_W + 1;
    localparam int ACC_W  = PROD_W + $clog2(NZ_PAIRS + 1) + 1;
    localparam int OUT_W  = DATA_W + 1;

    typedef struct packed {
        logic             phase;
        logic             vld;
        logic [OUT_W-1:0] y;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NZ_PAIRS-1:0][PRE_W-1:0]  pair_sum;
    logic [DATA_W-1:0]               centre;
    logic [NZ_PAIRS-1:0][PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]         acc;

    hb_tapline #(.DATA_W(DATA_W)) u_taps (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .pair_sum (pair_sum),
        .centre   (centre)
    );

    for (genvar i = 0; i < NZ_PAIRS; i++) begin : g_mul
        hb_csd_mult #(.IN_W(PRE_W), .COEF(NZ_COEF[i])) u_mul (
            .a (pair_sum[i]),
            .p (prod[i])
        );
    end

    // Centre weight one half: the sample placed one bit below coefficient unity.
    always_comb begin
        acc = ACC_W'($signed(centre)) <<< (COEF_FRAC - 1);
        for (int i = 0; i < NZ_PAIRS; i++) begin
            acc = acc + ACC_W'($signed(prod[i]));
        end
    end

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.vld = 1'b0;
        if (in_valid) begin
            ctl_d.phase = ~ctl_q.phase;
            if (ctl_q.phase) begin
                ctl_d.vld = 1'b1;
                ctl_d.y   = acc[COEF_FRAC +: OUT_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign out_valid = ctl_q.vld;
    assign out_data  = ctl_q.y;

    AST_OUT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R2
    AST_OUT_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R2
    AST_IDLE_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R3
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data)); // R8

endmodule

// File: tb/hb_decim2_bench.sv
`timescale 1ns/1ps
module hb_decim2_bench;

    localparam int DW = 24;
    localparam int OW = DW + 1;

    localparam logic signed [95:0] K_IN  = 96'sh24EC98258D1E;
    localparam logic signed [95:0] K_OUT = 96'sh200000000000 - 96'sh24EC98258D1E;
    localparam logic signed [95:0] K_MID = 96'sh400000000000;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic [DW-1:0]        in_data = '0;
    logic                 out_valid;
    logic [OW-1:0]        out_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cnt      = 0;
    logic signed [DW-1:0] hist [7];

    always #2.5 clk = ~clk;

    hb_decim2 #(.DATA_W(DW)) u_hb_decim2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int model_out();
        logic signed [95:0] s;
        logic signed [95:0] q;
        s = K_OUT * (96'(hist[0]) + 96'(hist[6]))
          + K_IN  * (96'(hist[2]) + 96'(hist[4]))
          + K_MID * 96'(hist[3]);
        q = s >>> 47;
        return int'($signed(q[OW-1:0]));
    endfunction

    // Called at a falling edge; drives one sample and checks the result.
    task automatic push(input string tag, input logic signed [DW-1:0] x);
        for (int k = 6; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
        cnt++;
        in_valid = 1'b1;
        in_data  = x;
        @(negedge clk);
        in_valid = 1'b0;
        if (cnt % 2 == 0) begin
            check({tag, " valid"}, int'(out_valid), 1);
            check(tag, int'($signed(out_data)), model_out());
        end else begin
            check("R2 no valid on odd input", int'(out_valid), 0);
        end
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        in_valid = 1'b0;
        for (int k = 0; k < 7; k++) hist[k] = '0;
        cnt = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 valid in reset", int'(out_valid), 0);
        check("R1 data in reset", int'(out_data), 0);
        do_reset();
        check("R1 valid after reset", int'(out_valid), 0);
        check("R1 data after reset", int'(out_data), 0);
    endtask

    task automatic t_impulse_odd();
        do_reset();
        push("R5 odd impulse", 24'sd4194304);
        for (int k = 0; k < 7; k++) begin
            push("R5 odd impulse", 24'sd0);
            if (cnt == 4) check("R5 centre half", int'($signed(out_data)), 2097152);
            if (cnt == 2 || cnt == 6) check("R5 zero tap", int'($signed(out_data)), 0);
        end
    endtask

    task automatic t_impulse_even();
        do_reset();
        push("R5 even impulse", 24'sd0);
        push("R5 even impulse", 24'sh7FFFFF);
        for (int k = 0; k < 8; k++) push("R4 even impulse", 24'sd0);
    endtask

    task automatic t_dc(input logic signed [DW-1:0] x);
        do_reset();
        for (int k = 0; k < 8; k++) push("R6 dc", x);
        check("R6 dc exact", int'($signed(out_data)), int'(x));
    endtask

    task automatic t_extreme(input logic signed [DW-1:0] hi, input logic signed [DW-1:0] lo);
        do_reset();
        push("R7 extreme", 24'sd0);
        push("R7 extreme", lo);
        push("R7 extreme", 24'sd0);
        push("R7 extreme", hi);
        push("R7 extreme", hi);
        push("R7 extreme", hi);
        push("R7 extreme", 24'sd0);
        push("R7 extreme", lo);
    endtask

    task automatic t_random();
        do_reset();
        for (int k = 0; k < 200; k++) begin
            push("R4 random", DW'($urandom));
        end
    endtask

    task automatic t_gaps();
        int hold;
        do_reset();
        for (int k = 0; k < 40; k++) begin
            push("R3 gapped", DW'($urandom));
            hold = int'(out_data);
            for (int g = 0; g < int'(k % 3); g++) begin
                in_data = DW'($urandom);
                @(negedge clk);
                check("R3 idle no valid", int'(out_valid), 0);
                check("R8 hold", int'(out_data), hold);
            end
        end
    endtask

    task automatic t_midreset();
        do_reset();
        for (int k = 0; k < 5; k++) push("R4 pre-reset", 24'sh654321);
        do_reset();
        for (int k = 0; k < 8; k++) begin
            push("R9 history cleared", 24'sd0);
            if (cnt % 2 == 0) check("R9 zero out", int'($signed(out_data)), 0);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < 7; k++) hist[k] = '0;
        t_reset();
        t_impulse_odd();
        t_impulse_even();
        t_dc(24'sd1000);
        t_dc(-24'sd5000000);
        t_dc(24'sh7FFFFF);
        t_extreme(24'sh7FFFFF, 24'sh800000);
        t_extreme(24'sh800000, 24'sh7FFFFF);
        t_random();
        t_gaps();
        t_midreset();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule